// File: doc/BRIEF.md
# Tile Rotating Band Reorderer

This block takes a raster stream of pixels and re-emits it as a sequence of 8x8 tiles. It collects one band of eight lines in an internal store. Once the band is complete, it drains the tiles left to right, 64 pixels per tile. While a tile drains, the block can turn it by 0, 90, 180 or 270 degrees clockwise. Inside each tile, pixels leave either row by row or in Z-order (Morton) sequence, and the Z-order is applied to the output coordinates after the turn.

There are two band stores. The next band fills while the previous one drains. When both stores are full, the input side is held off. Each fully drained band raises a one-cycle pulse, which a downstream transfer engine can use as its request.

Both streams use a valid/ready handshake. The line width is given in tiles. The turn and order settings are static inputs.

Top module: `tile_rotator`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `band_done` is 0.
- R2: An input pixel is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Pixels fill a band in raster order with `cfg_tiles`*8 pixels per line and 8 lines per band.
- R3: With `cfg_rot`=0 and `cfg_swz`=0, output index k (0..63) of a tile carries tile pixel (row k/8, column k%8).
- R4: With `cfg_rot`=1 (90 degrees clockwise), output position (r,c) carries tile input pixel (7-c, r).
- R5: With `cfg_rot`=2 (180 degrees), output position (r,c) carries tile input pixel (7-r, 7-c).
- R6: With `cfg_rot`=3 (270 degrees clockwise), output position (r,c) carries tile input pixel (c, 7-r).
- R7: With `cfg_swz`=1, output index k maps to output column {k[4],k[2],k[0]} and row {k[5],k[3],k[1]}. The turn from R3 to R6 is then applied to that (r,c).
- R8: Tiles of a band are emitted in order of increasing column, 64 pixels each, and a band is emitted only after it is complete.
- R9: `band_done` is high for exactly one cycle, in the cycle after the last pixel of a band is accepted at the output.
- R10: While one band drains, the next band is accepted. When both stores hold complete bands, `in_ready` is 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_pix` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tiles | input | $clog2(MAX_TILES+1) | Tiles per line, 1..MAX_TILES |
| cfg_rot | input | 2 | Clockwise turn in quarter turns, 0..3 |
| cfg_swz | input | 1 | 1 selects Z-order within a tile |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel can be taken |
| in_pix | input | PIX_W | Input pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output pixel taken |
| out_pix | output | PIX_W | Output pixel |
| band_done | output | 1 | One-cycle pulse per drained band |

## Verification
The assertions assume three things about the inputs. `cfg_tiles`, `cfg_rot` and `cfg_swz` stay constant while any band is held or being written. `cfg_tiles` stays within 1..MAX_TILES. Line length and band count are whole numbers of tiles and bands. The stimulus changes the settings only between runs, after every band has drained and the input side is idle. It draws the tile count from the legal range only and always sends complete bands. Random gaps and random `out_ready` throttling vary the timing without breaking these conditions.

// File: rtl/tile_rot_pkg.sv
package tile_rot_pkg;

  typedef logic [2:0] coord_t;

  typedef struct packed {
    coord_t row;
    coord_t col;
  } tpos_t;

  // Output position for sequence index k: raster or Z-order (x bit lowest)
  function automatic tpos_t seq_to_pos(input logic [5:0] k, input logic swz);
    tpos_t p;
    if (swz) begin
      p.col = {k[4], k[2], k[0]};
      p.row = {k[5], k[3], k[1]};
    end else begin
      p.row = k[5:3];
      p.col = k[2:0];
    end
    return p;
  endfunction

  // Source pixel inside the tile for an output position and a clockwise turn
  function automatic tpos_t rot_src(input tpos_t o, input logic [1:0] rot);
    tpos_t s;
    case (rot)
      2'd1:    begin s.row = 3'd7 - o.col; s.col = o.row;         end
      2'd2:    begin s.row = 3'd7 - o.row; s.col = 3'd7 - o.col;  end
      2'd3:    begin s.row = o.col;        s.col = 3'd7 - o.row;  end
      default: begin s.row = o.row;        s.col = o.col;         end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/band_store.sv
module band_store #(
  parameter int PIX_W     = 16,
  parameter int MAX_TILES = 4,
  localparam int COL_N    = MAX_TILES * 8,
  localparam int COL_W    = $clog2(COL_N)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [2:0]       wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [PIX_W-1:0] wr_pix,
  input  logic             rd_bank,
  input  logic [2:0]       rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [PIX_W-1:0] rd_pix
);

  logic [PIX_W-1:0] mem [2][8][COL_N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_bank][wr_row][wr_col] <= wr_pix;
  end

  assign rd_pix = mem[rd_bank][rd_row][rd_col];

endmodule

// File: rtl/band_wr_ctrl.sv
module band_wr_ctrl #(
  parameter int MAX_TILES = 4,
  localparam int CT_W     = $clog2(MAX_TILES + 1),
  localparam int COL_W    = $clog2(MAX_TILES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CT_W-1:0]  cfg_tiles,
  input  logic             in_valid,
  input  logic [1:0]       bank_full,
  output logic             in_ready,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [2:0]       wr_row,
  output logic [COL_W-1:0] wr_col,
  output logic             band_filled
);

  logic [COL_W:0] line_len;
  logic           last_col;

  assign line_len    = (COL_W+1)'({cfg_tiles, 3'b000});
  assign last_col    = ({1'b0, wr_col} == line_len - 1'b1);
  assign in_ready    = !bank_full[wr_bank];
  assign wr_en       = in_valid && in_ready;
  assign band_filled = wr_en && last_col && (wr_row == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
    end else if (wr_en) begin
      if (last_col) begin
        wr_col <= '0;
        wr_row <= wr_row + 3'd1;
        if (wr_row == 3'd7) wr_bank <= !wr_bank;
      end else begin
        wr_col <= wr_col + 1'b1;
      end
    end
  end

  AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wr_col} < line_len)); // R2

endmodule

// File: rtl/band_rd_ctrl.sv
module band_rd_ctrl
  import tile_rot_pkg::*;
#(
  parameter int MAX_TILES = 4,
  localparam int CT_W     = $clog2(MAX_TILES + 1),
  localparam int COL_W    = $clog2(MAX_TILES * 8),
  localparam int TIDX_W   = COL_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CT_W-1:0]  cfg_tiles,
  input  logic [1:0]       cfg_rot,
  input  logic             cfg_swz,
  input  logic [1:0]       bank_full,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             rd_bank,
  output logic [2:0]       rd_row,
  output logic [COL_W-1:0] rd_col,
  output logic             band_drained,
  output logic             band_done
);

  logic [5:0]        seq;
  logic [TIDX_W-1:0] tile;
  logic              fire;
  logic              last_tile;
  tpos_t             opos;
  tpos_t             spos;

  assign opos      = seq_to_pos(seq, cfg_swz);
  assign spos      = rot_src(opos, cfg_rot);
  assign rd_row    = spos.row;
  assign rd_col    = {tile, spos.col};            // R8 tile column base
  assign out_valid = bank_full[rd_bank];
  assign fire      = out_valid && out_ready;
  assign last_tile = (tile == TIDX_W'(cfg_tiles - 1'b1));
  assign band_drained = fire && (seq == 6'd63) && last_tile;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= '0;
      tile      <= '0;
      rd_bank   <= 1'b0;
      band_done <= 1'b0;
    end else begin
      band_done <= band_drained;
      if (fire) begin
        seq <= seq + 6'd1;
        if (seq == 6'd63) begin
          if (last_tile) begin
            tile    <= '0;
            rd_bank <= !rd_bank;
          end else begin
            tile <= tile + 1'b1;
          end
        end
      end
    end
  end

  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seq == 6'd63) |=> (seq == 6'd0)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    band_done |=> !band_done); // R9

endmodule

// File: rtl/tile_rotator.sv
module tile_rotator #(
  parameter int PIX_W     = 16,
  parameter int MAX_TILES = 4,
  localparam int CT_W     = $clog2(MAX_TILES + 1),
  localparam int COL_W    = $clog2(MAX_TILES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CT_W-1:0]  cfg_tiles,
  input  logic [1:0]       cfg_rot,
  input  logic             cfg_swz,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             band_done
);

  logic [1:0]       full_q;
  logic             wr_en;
  logic             wr_bank;
  logic [2:0]       wr_row;
  logic [COL_W-1:0] wr_col;
  logic             band_filled;
  logic             rd_bank;
  logic [2:0]       rd_row;
  logic [COL_W-1:0] rd_col;
  logic             band_drained;

  band_wr_ctrl #(.MAX_TILES(MAX_TILES)) u_wr (
    .clk(clk), .rst_n(rst_n), .cfg_tiles(cfg_tiles), .in_valid(in_valid),
    .bank_full(full_q), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .band_filled(band_filled)
  );

  band_rd_ctrl #(.MAX_TILES(MAX_TILES)) u_rd (
    .clk(clk), .rst_n(rst_n), .cfg_tiles(cfg_tiles), .cfg_rot(cfg_rot),
    .cfg_swz(cfg_swz), .bank_full(full_q), .out_ready(out_ready),
    .out_valid(out_valid), .rd_bank(rd_bank), .rd_row(rd_row),
    .rd_col(rd_col), .band_drained(band_drained), .band_done(band_done)
  );

  band_store #(.PIX_W(PIX_W), .MAX_TILES(MAX_TILES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
    .wr_col(wr_col), .wr_pix(in_pix), .rd_bank(rd_bank), .rd_row(rd_row),
    .rd_col(rd_col), .rd_pix(out_pix)
  );

  // Bank ownership: writer sets, reader clears; never the same bank at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 2'b00;
    end else begin
      if (band_filled)  full_q[wr_bank] <= 1'b1;
      if (band_drained) full_q[rd_bank] <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    band_filled |-> !full_q[wr_bank]); // R10

  AST_STALL_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_q) |-> !in_ready); // R10

  AST_DRAIN_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    band_drained |-> full_q[rd_bank]); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R11

endmodule

// File: tb/tile_rotator_bench.sv
module tile_rotator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 16;
  localparam int MAX_TILES  = 4;
  localparam int CT_W       = $clog2(MAX_TILES + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CT_W-1:0]  cfg_tiles = CT_W'(1);
  logic [1:0]       cfg_rot = 2'd0;
  logic             cfg_swz = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PIX_W-1:0] in_pix = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [PIX_W-1:0] out_pix;
  logic             band_done;

  int total = 0;
  int bad   = 0;
  int gslot = 0;
  logic [PIX_W-1:0] model [4][8][MAX_TILES*8];

  always #(CLK_PERIOD/2) clk = !clk;

  tile_rotator #(.PIX_W(PIX_W), .MAX_TILES(MAX_TILES)) u_tile_rotator (
    .clk(clk), .rst_n(rst_n), .cfg_tiles(cfg_tiles), .cfg_rot(cfg_rot),
    .cfg_swz(cfg_swz), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .band_done(band_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Source (row,col) in tile: output position then repeated quarter turns
  function automatic void exp_src(input int k, input int rot, input bit swz,
                                  output int sr, output int sc);
    int r, c, t;
    r = 0; c = 0;
    if (swz) begin
      for (int i = 0; i < 3; i++) begin
        c = c | (((k >> (2*i)) & 1) << i);
        r = r | (((k >> (2*i+1)) & 1) << i);
      end
    end else begin
      r = k / 8;
      c = k % 8;
    end
    for (int n = 0; n < rot; n++) begin
      t = 7 - c;
      c = r;
      r = t;
    end
    sr = r; sc = c;
  endfunction

  function automatic string req_tag(input int rot, input bit swz);
    if (swz) return "R7";
    case (rot)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R3";
    endcase
  endfunction

  // R2: raster fill, random idle gaps
  task automatic produce(input int slot0, input int nb, input int tiles, input int gap_pct);
    for (int b = 0; b < nb; b++) begin
      for (int r = 0; r < 8; r++) begin
        for (int c = 0; c < tiles*8; c++) begin
          logic [PIX_W-1:0] p;
          @(negedge clk);
          while (($urandom % 100) < gap_pct) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          p = PIX_W'($urandom);
          model[(slot0+b)%4][r][c] = p;
          in_valid = 1'b1;
          in_pix   = p;
          while (!in_ready) @(negedge clk);
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic consume(input int slot0, input int nb, input int tiles,
                         input int rot, input bit swz, input int rdy_pct);
    bit pend;
    int sr, sc;
    pend = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int t = 0; t < tiles; t++) begin
        for (int k = 0; k < 64; k++) begin
          bit got;
          got = 1'b0;
          while (!got) begin
            @(negedge clk);
            if (pend || band_done) check(band_done == pend, "R9", band_done, pend);
            pend = 1'b0;
            out_ready = (($urandom % 100) < rdy_pct);
            if (out_valid && out_ready) begin
              exp_src(k, rot, swz, sr, sc);
              // R8: tile t occupies columns t*8..t*8+7
              check(out_pix == model[(slot0+b)%4][sr][t*8+sc], req_tag(rot, swz),
                    out_pix, model[(slot0+b)%4][sr][t*8+sc]);
              got = 1'b1;
              if (k == 63 && t == tiles-1) pend = 1'b1;
            end
          end
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(band_done == pend, "R9", band_done, pend);
    @(negedge clk);
    check(band_done == 1'b0, "R9", band_done, 0);
  endtask

  task automatic run(input int tiles, input int rot, input bit swz, input int nb,
                     input int gap_pct, input int rdy_pct);
    @(negedge clk);
    cfg_tiles = CT_W'(tiles);
    cfg_rot   = 2'(rot);
    cfg_swz   = swz;
    fork
      produce(gslot, nb, tiles, gap_pct);
      consume(gslot, nb, tiles, rot, swz, rdy_pct);
    join
    gslot = (gslot + nb) % 4;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R2", {in_ready, out_valid}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PIX_W-1:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(band_done == 1'b0, "R1", band_done, 0);

    // Directed: each turn, raster order
    run(2, 0, 1'b0, 2, 0, 100);
    run(2, 1, 1'b0, 2, 10, 90);
    run(3, 2, 1'b0, 1, 20, 60);
    run(1, 3, 1'b0, 2, 0, 50);
    // Z-order with turns, width extremes
    run(MAX_TILES, 0, 1'b1, 2, 10, 80);
    run(1, 1, 1'b1, 3, 30, 70);

    // Directed stall: fill both stores with output blocked (R10, R11)
    @(negedge clk);
    cfg_tiles = CT_W'(2); cfg_rot = 2'd2; cfg_swz = 1'b1;
    out_ready = 1'b0;
    produce(gslot, 1, 2, 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R10", in_ready, 1);
    check(out_valid == 1'b1, "R8", out_valid, 1);
    produce((gslot+1)%4, 1, 2, 0);
    @(negedge clk);
    check(in_ready == 1'b0, "R10", in_ready, 0);
    held = out_pix;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R11", out_valid, 1);
    check(out_pix == held, "R11", out_pix, held);
    consume(gslot, 2, 2, 2, 1'b1, 60);
    gslot = (gslot + 2) % 4;

    // Constrained random runs
    for (int i = 0; i < 6; i++) begin
      run(1 + ($urandom % MAX_TILES), $urandom % 4, 1'($urandom % 2),
          1 + ($urandom % 3), $urandom % 40, 40 + ($urandom % 60));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule